// File: doc/BRIEF.md
# SDRAM Self-Refresh Command Sequencer

This block sits inside an SDRAM controller and drives the memory's command pins (chip select, RAS, CAS, WE, clock enable and address bit 10) to put the device into self refresh and take it out again. Software issues commands by writing a 3-bit code. An all-bank precharge must come first. A self-refresh entry request is then held until a programmable precharge wait has passed, and it is refused if no precharge has happened since the last row activation or since reset.

While the memory refreshes itself, the block drops clock enable and holds it low. In this period it stops the controller's periodic auto-refresh requests and blocks every read and write access. A software exit command raises clock enable and drives NOP cycles for a programmable recovery time before normal traffic resumes. A system reset also takes the memory out of self refresh: it clears all state, leaves auto refresh disabled and runs the same NOP recovery before accesses are granted.

Top module: `sdr_sr_seq`

## Requirements
- R1: While reset is held and for EXIT_CYC cycles after its release, the pins show NOP (CS_n=0, RAS_n=1, CAS_n=1, WE_n=1, A10=0) with CKE=1, the status is 0, auto refresh is off and no access is granted. From cycle EXIT_CYC after release, accesses are granted.
- R2: A write of code 3'b010 while idle drives one precharge-all cycle (CS_n=0, RAS_n=0, CAS_n=1, WE_n=0, A10=1, CKE=1) in the cycle after the write, followed by NOP.
- R3: A write of code 3'b101 drives the entry command (CS_n=0, RAS_n=0, CAS_n=0, WE_n=1) with CKE falling from 1 to 0 in the same cycle. It is never driven earlier than PRE_CYC cycles after the precharge cycle. If written during that wait, the command field reads 3'b101 until the entry is issued and then reads 3'b000. If written while idle with no activation since the last precharge, it issues in the next cycle.
- R4: An entry request is refused if no precharge has occurred since reset or since the last row activation (bank_act_i). The pins stay NOP and the status stays 0.
- R5: CKE stays 0 for the whole self-refresh period, with NOP on the other pins. The status reads 1 from the entry cycle onward.
- R6: A write of code 3'b110 in self refresh raises CKE in the next cycle. NOP is then held with the status at 1 for EXIT_CYC cycles, after which the status clears.
- R7: A write of code 3'b100 turns auto refresh on. A request on arf_req_i then produces one auto-refresh cycle (CS_n=0, RAS_n=0, CAS_n=0, WE_n=1, CKE=1) two cycles later. No auto refresh is issued while the status is 1, and requests that arrive in self refresh are discarded.
- R8: acc_gnt_o follows acc_req_i only when the block is idle. Accesses are blocked during the precharge wait, self refresh, exit recovery and post-reset recovery.
- R9: Reserved codes 3'b001, 3'b011 and 3'b111, and codes that do not apply in the present state (exit while idle; precharge or entry while in self refresh), change nothing.
- R10: A reset asserted during self refresh at once drives CKE=1 with NOP, status 0 and auto refresh off. Afterwards, entry is refused until a new precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cfg_wr_i | input | 1 | Command field write strobe |
| cfg_cmd_i | input | 3 | Command code written |
| bank_act_i | input | 1 | Pulse: datapath opened a row |
| arf_req_i | input | 1 | Periodic refresh request from the timer |
| acc_req_i | input | 1 | Read/write access request |
| acc_gnt_o | output | 1 | Access may proceed |
| acc_block_o | output | 1 | Accesses are currently blocked |
| sdr_cs_n_o | output | 1 | SDRAM chip select, active low |
| sdr_ras_n_o | output | 1 | SDRAM RAS, active low |
| sdr_cas_n_o | output | 1 | SDRAM CAS, active low |
| sdr_we_n_o | output | 1 | SDRAM WE, active low |
| sdr_a10_o | output | 1 | SDRAM address bit 10 |
| sdr_cke_o | output | 1 | SDRAM clock enable |
| cmd_field_o | output | 3 | Command field readback |
| sr_active_o | output | 1 | Self-refresh status |
| arf_run_o | output | 1 | Auto-refresh engine running |

## Verification
The hardest state to reach is an entry request that is pending while the precharge wait runs. To get there, the stimulus writes the entry code in the cycle right after the precharge code, then checks that the command field shows the pending code and that the entry lands exactly PRE_CYC cycles after the precharge. A second hard case is a refresh request that arrives in self refresh and must not reappear after exit. The bench raises that request together with ignored writes during self refresh, then checks the cycle after recovery for its absence.

// File: rtl/sdr_sr_pkg.sv
package sdr_sr_pkg;

    localparam logic [2:0] CODE_IDLE   = 3'b000;
    localparam logic [2:0] CODE_PREALL = 3'b010;
    localparam logic [2:0] CODE_ARF_ON = 3'b100;
    localparam logic [2:0] CODE_ENTER  = 3'b101;
    localparam logic [2:0] CODE_LEAVE  = 3'b110;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PREALL,
        OP_ARF_ON,
        OP_ENTER,
        OP_LEAVE
    } sr_op_e;

    typedef enum logic [2:0] {
        ST_WAKE,
        ST_IDLE,
        ST_PWAIT,
        ST_SELF,
        ST_EXIT
    } sr_st_e;

    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } sdr_pins_t;

    function automatic sdr_pins_t pins_nop(input logic cke);
        return '{cke: cke, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    endfunction

    function automatic sdr_pins_t pins_preall();
        return '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
    endfunction

    function automatic sdr_pins_t pins_enter();
        return '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
    endfunction

    function automatic sdr_pins_t pins_aref();
        return '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
    endfunction

endpackage

// File: rtl/sdr_sr_cmd_dec.sv
module sdr_sr_cmd_dec
    import sdr_sr_pkg::*;
(
    input  logic       wr_i,
    input  logic [2:0] code_i,
    output sr_op_e     op_o
);

    always_comb begin
        op_o = OP_NONE;
        if (wr_i) begin
            unique case (code_i)
                CODE_PREALL: op_o = OP_PREALL;
                CODE_ARF_ON: op_o = OP_ARF_ON;
                CODE_ENTER:  op_o = OP_ENTER;
                CODE_LEAVE:  op_o = OP_LEAVE;
                default:     op_o = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sdr_sr_dcnt.sv
module sdr_sr_dcnt #(
    parameter int W       = 4,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdr_sr_arf.sv
module sdr_sr_arf (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic suspend_i,
    input  logic req_i,
    input  logic issue_i,
    output logic pend_o
);

    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (!enable_i || suspend_i) begin
            pend_d = 1'b0;
        end else if (req_i) begin
            pend_d = 1'b1;
        end else if (issue_i) begin
            pend_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/sdr_sr_seq.sv
module sdr_sr_seq
    import sdr_sr_pkg::*;
#(
    parameter int PRE_CYC  = 3,
    parameter int EXIT_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr_i,
    input  logic [2:0] cfg_cmd_i,
    input  logic       bank_act_i,
    input  logic       arf_req_i,
    input  logic       acc_req_i,
    output logic       acc_gnt_o,
    output logic       acc_block_o,
    output logic       sdr_cs_n_o,
    output logic       sdr_ras_n_o,
    output logic       sdr_cas_n_o,
    output logic       sdr_we_n_o,
    output logic       sdr_a10_o,
    output logic       sdr_cke_o,
    output logic [2:0] cmd_field_o,
    output logic       sr_active_o,
    output logic       arf_run_o
);

    localparam int MAX_CYC = (PRE_CYC > EXIT_CYC) ? PRE_CYC : EXIT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PRE_LD  = CNT_W'(PRE_CYC - 1);
    localparam logic [CNT_W-1:0] EXIT_LD = CNT_W'(EXIT_CYC - 1);

    typedef struct packed {
        sr_st_e     st;
        logic       clean;
        logic       pend_enter;
        logic       arf_on;
        logic [2:0] field;
        sdr_pins_t  pins;
    } seq_state_t;

    seq_state_t       s_d, s_q;
    sr_op_e           op;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;
    logic             arf_pend;
    logic             arf_issue;
    logic             in_sr;
    logic             want_enter;

    sdr_sr_cmd_dec u_dec (
        .wr_i   (cfg_wr_i),
        .code_i (cfg_cmd_i),
        .op_o   (op)
    );

    sdr_sr_dcnt #(
        .W       (CNT_W),
        .RST_VAL (EXIT_CYC - 1)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_load),
        .val_i  (cnt_val),
        .zero_o (cnt_zero)
    );

    assign in_sr = (s_q.st == ST_SELF) || (s_q.st == ST_EXIT);

    sdr_sr_arf u_arf (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (s_q.arf_on),
        .suspend_i (in_sr),
        .req_i     (arf_req_i),
        .issue_i   (arf_issue),
        .pend_o    (arf_pend)
    );

    always_comb begin
        s_d        = s_q;
        s_d.pins   = pins_nop(1'b1);
        cnt_load   = 1'b0;
        cnt_val    = '0;
        arf_issue  = 1'b0;
        want_enter = s_q.pend_enter || (op == OP_ENTER);

        if (bank_act_i) begin
            s_d.clean = 1'b0;
        end
        if (op == OP_ARF_ON && s_q.st != ST_WAKE) begin
            s_d.arf_on = 1'b1;
        end

        unique case (s_q.st)
            ST_WAKE: begin
                if (cnt_zero) begin
                    s_d.st = ST_IDLE;
                end
            end
            ST_IDLE: begin
                s_d.field = CODE_IDLE;
                if (op == OP_PREALL) begin
                    s_d.pins  = pins_preall();
                    s_d.clean = 1'b1;
                    s_d.st    = ST_PWAIT;
                    cnt_load  = 1'b1;
                    cnt_val   = PRE_LD;
                end else if (op == OP_ENTER && s_q.clean && !bank_act_i) begin
                    s_d.pins = pins_enter();
                    s_d.st   = ST_SELF;
                end else if (arf_pend) begin
                    s_d.pins  = pins_aref();
                    arf_issue = 1'b1;
                end
            end
            ST_PWAIT: begin
                if (op == OP_ENTER) begin
                    s_d.pend_enter = 1'b1;
                    s_d.field      = CODE_ENTER;
                end
                if (cnt_zero) begin
                    s_d.st         = ST_IDLE;
                    s_d.pend_enter = 1'b0;
                    s_d.field      = CODE_IDLE;
                    if (want_enter && s_q.clean && !bank_act_i) begin
                        s_d.pins = pins_enter();
                        s_d.st   = ST_SELF;
                    end
                end
            end
            ST_SELF: begin
                s_d.pins = pins_nop(1'b0);
                if (op == OP_LEAVE) begin
                    s_d.pins = pins_nop(1'b1);
                    s_d.st   = ST_EXIT;
                    cnt_load = 1'b1;
                    cnt_val  = EXIT_LD;
                end
            end
            ST_EXIT: begin
                if (cnt_zero) begin
                    s_d.st = ST_IDLE;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st         <= ST_WAKE;
            s_q.clean      <= 1'b0;
            s_q.pend_enter <= 1'b0;
            s_q.arf_on     <= 1'b0;
            s_q.field      <= CODE_IDLE;
            s_q.pins       <= pins_nop(1'b1);
        end else begin
            s_q <= s_d;
        end
    end

    assign acc_block_o = (s_q.st != ST_IDLE);
    assign acc_gnt_o   = acc_req_i && (s_q.st == ST_IDLE);
    assign sdr_cke_o   = s_q.pins.cke;
    assign sdr_cs_n_o  = s_q.pins.cs_n;
    assign sdr_ras_n_o = s_q.pins.ras_n;
    assign sdr_cas_n_o = s_q.pins.cas_n;
    assign sdr_we_n_o  = s_q.pins.we_n;
    assign sdr_a10_o   = s_q.pins.a10;
    assign cmd_field_o = s_q.field;
    assign sr_active_o = in_sr;
    assign arf_run_o   = s_q.arf_on && !in_sr;

endmodule

// File: rtl/sdr_sr_seq_chk.sv
module sdr_sr_seq_chk #(
    parameter int PRE_CYC = 3
) (
    input logic clk,
    input logic rst_n,
    input logic sdr_cke_o,
    input logic sdr_cs_n_o,
    input logic sdr_ras_n_o,
    input logic sdr_cas_n_o,
    input logic sdr_we_n_o,
    input logic sdr_a10_o,
    input logic sr_active_o,
    input logic acc_gnt_o,
    input logic arf_run_o
);

    int  since_pre;
    logic is_pre;
    logic is_rc_w1;

    assign is_pre   = !sdr_cs_n_o && !sdr_ras_n_o && sdr_cas_n_o && !sdr_we_n_o && sdr_a10_o;
    assign is_rc_w1 = !sdr_cs_n_o && !sdr_ras_n_o && !sdr_cas_n_o && sdr_we_n_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_pre <= 0;
        end else if (is_pre) begin
            since_pre <= 1;
        end else if (since_pre != 0 && since_pre < PRE_CYC) begin
            since_pre <= since_pre + 1;
        end
    end

    p_enter_encoding_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdr_cke_o) |-> is_rc_w1);

    p_enter_after_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdr_cke_o) |-> (since_pre >= PRE_CYC));

    p_cke_low_only_sr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sdr_cke_o |-> sr_active_o);

    p_pre_single_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |=> (sdr_ras_n_o && sdr_cas_n_o && sdr_we_n_o));

    p_no_aref_in_sr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rc_w1 && sdr_cke_o) |-> !sr_active_o);

    p_arf_suspended_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active_o |-> !arf_run_o);

    p_no_grant_sr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active_o |-> !acc_gnt_o);

    p_exit_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdr_cke_o) |-> (sr_active_o && sdr_ras_n_o && sdr_cas_n_o && sdr_we_n_o));

endmodule

bind sdr_sr_seq sdr_sr_seq_chk #(
    .PRE_CYC (PRE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sdr_cke_o   (sdr_cke_o),
    .sdr_cs_n_o  (sdr_cs_n_o),
    .sdr_ras_n_o (sdr_ras_n_o),
    .sdr_cas_n_o (sdr_cas_n_o),
    .sdr_we_n_o  (sdr_we_n_o),
    .sdr_a10_o   (sdr_a10_o),
    .sr_active_o (sr_active_o),
    .acc_gnt_o   (acc_gnt_o),
    .arf_run_o   (arf_run_o)
);

// File: tb/tb_sdr_sr_seq.sv
module tb_sdr_sr_seq;

    localparam int PRE_CYC  = 3;
    localparam int EXIT_CYC = 8;

    localparam logic [5:0] P_NOP = 6'b101110;
    localparam logic [5:0] P_PRE = 6'b100101;
    localparam logic [5:0] P_ENT = 6'b000010;
    localparam logic [5:0] P_SRN = 6'b001110;
    localparam logic [5:0] P_ARF = 6'b100010;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_cmd = 3'b000;
    logic       bank_act = 1'b0;
    logic       arf_req = 1'b0;
    logic       acc_req = 1'b0;
    logic       acc_gnt, acc_block;
    logic       cs_n, ras_n, cas_n, we_n, a10, cke;
    logic [2:0] fld;
    logic       sr, arf_run;
    logic [5:0] pins;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         cyc;
        logic [5:0] pins;
        logic       sr;
        logic [2:0] fld;
        logic       arf;
        string      tag;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    assign pins = {cke, cs_n, ras_n, cas_n, we_n, a10};

    sdr_sr_seq #(
        .PRE_CYC  (PRE_CYC),
        .EXIT_CYC (EXIT_CYC)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_i    (cfg_wr),
        .cfg_cmd_i   (cfg_cmd),
        .bank_act_i  (bank_act),
        .arf_req_i   (arf_req),
        .acc_req_i   (acc_req),
        .acc_gnt_o   (acc_gnt),
        .acc_block_o (acc_block),
        .sdr_cs_n_o  (cs_n),
        .sdr_ras_n_o (ras_n),
        .sdr_cas_n_o (cas_n),
        .sdr_we_n_o  (we_n),
        .sdr_a10_o   (a10),
        .sdr_cke_o   (cke),
        .cmd_field_o (fld),
        .sr_active_o (sr),
        .arf_run_o   (arf_run)
    );

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input int c, input logic [5:0] p, input logic s,
                        input logic [2:0] f, input logic a, input string t);
        item_t it;
        it.cyc = c; it.pins = p; it.sr = s; it.fld = f; it.arf = a; it.tag = t;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [2:0] c);
        cfg_wr  = 1'b1;
        cfg_cmd = c;
        @(negedge clk);
        cfg_wr  = 1'b0;
        cfg_cmd = 3'b000;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop expected items as their cycle comes up
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            item_t it;
            it = sb.pop_front();
            if (it.cyc < cyc) begin
                check(1'b0, it.tag, "missed", $sformatf("cycle %0d", it.cyc));
            end else begin
                check({pins, sr, fld, arf_run} == {it.pins, it.sr, it.fld, it.arf}, it.tag,
                      $sformatf("pins=%b sr=%b fld=%b arf=%b", pins, sr, fld, arf_run),
                      $sformatf("pins=%b sr=%b fld=%b arf=%b", it.pins, it.sr, it.fld, it.arf));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        tick(4);
        // R1: state held during reset
        check({pins, sr, arf_run} == {P_NOP, 1'b0, 1'b0}, "R1 reset state",
              $sformatf("%b %b %b", pins, sr, arf_run), $sformatf("%b 0 0", P_NOP));
        rst_n   = 1'b1;
        acc_req = 1'b1;
        tick(EXIT_CYC - 1);
        check(!acc_gnt && acc_block, "R1 recovery blocks access",
              $sformatf("gnt=%b", acc_gnt), "gnt=0");
        tick(1);
        check(acc_gnt && !acc_block, "R8 grant when idle",
              $sformatf("gnt=%b", acc_gnt), "gnt=1");
        acc_req = 1'b0;

        // R4: no precharge yet since reset
        n = cyc;
        push(n + 1, P_NOP, 1'b0, 3'b000, 1'b0, "R4 entry refused without precharge");
        push(n + 3, P_NOP, 1'b0, 3'b000, 1'b0, "R4 still idle");
        wr(3'b101);
        tick(3);

        // R9: reserved codes and exit while idle
        n = cyc; push(n + 1, P_NOP, 1'b0, 3'b000, 1'b0, "R9 code 001"); wr(3'b001);
        n = cyc; push(n + 1, P_NOP, 1'b0, 3'b000, 1'b0, "R9 code 011"); wr(3'b011);
        n = cyc; push(n + 1, P_NOP, 1'b0, 3'b000, 1'b0, "R9 code 111"); wr(3'b111);
        n = cyc; push(n + 1, P_NOP, 1'b0, 3'b000, 1'b0, "R9 exit when idle"); wr(3'b110);
        tick(2);

        // R7: enable auto refresh and service a request
        n = cyc; push(n + 1, P_NOP, 1'b0, 3'b000, 1'b1, "R7 enable"); wr(3'b100);
        n = cyc;
        arf_req = 1'b1;
        tick(1);
        arf_req = 1'b0;
        push(n + 2, P_ARF, 1'b0, 3'b000, 1'b1, "R7 auto refresh issued");
        push(n + 3, P_NOP, 1'b0, 3'b000, 1'b1, "R7 single auto refresh");
        tick(4);

        // R2, R3: precharge, entry pending during wait
        n = cyc;
        push(n + 1, P_PRE, 1'b0, 3'b000, 1'b1, "R2 precharge all");
        wr(3'b010);
        push(n + 2, P_NOP, 1'b0, 3'b101, 1'b1, "R3 entry pending");
        push(n + 3, P_NOP, 1'b0, 3'b101, 1'b1, "R3 wait not over");
        push(n + 4, P_ENT, 1'b1, 3'b000, 1'b0, "R3 entry after wait");
        push(n + 5, P_SRN, 1'b1, 3'b000, 1'b0, "R5 cke low in self refresh");
        wr(3'b101);
        acc_req = 1'b1;
        check(!acc_gnt, "R8 blocked during precharge wait", $sformatf("gnt=%b", acc_gnt), "gnt=0");
        tick(4);
        check(!acc_gnt && acc_block, "R8 blocked in self refresh", $sformatf("gnt=%b", acc_gnt), "gnt=0");
        acc_req = 1'b0;

        // R5, R7, R9: ignored traffic in self refresh
        n = cyc;
        arf_req = 1'b1;
        push(n + 1, P_SRN, 1'b1, 3'b000, 1'b0, "R9 precharge ignored in self refresh");
        wr(3'b010);
        arf_req = 1'b0;
        wr(3'b101);
        push(n + 6, P_SRN, 1'b1, 3'b000, 1'b0, "R5 cke held low");
        tick(4);

        // R6: exit with recovery
        n = cyc;
        push(n + 1, P_NOP, 1'b1, 3'b000, 1'b0, "R6 cke rises");
        push(n + EXIT_CYC, P_NOP, 1'b1, 3'b000, 1'b0, "R6 status held during recovery");
        push(n + EXIT_CYC + 1, P_NOP, 1'b0, 3'b000, 1'b1, "R6 status cleared");
        push(n + EXIT_CYC + 2, P_NOP, 1'b0, 3'b000, 1'b1, "R7 request in self refresh dropped");
        wr(3'b110);
        tick(EXIT_CYC + 3);

        // R3: direct entry from idle, banks still closed
        n = cyc;
        push(n + 1, P_ENT, 1'b1, 3'b000, 1'b0, "R3 direct entry");
        wr(3'b101);
        tick(2);

        // R10: reset during self refresh
        rst_n = 1'b0;
        tick(1);
        check({pins, sr, arf_run} == {P_NOP, 1'b0, 1'b0}, "R10 reset exits self refresh",
              $sformatf("%b %b %b", pins, sr, arf_run), $sformatf("%b 0 0", P_NOP));
        rst_n = 1'b1;
        tick(EXIT_CYC + 2);
        n = cyc;
        push(n + 1, P_NOP, 1'b0, 3'b000, 1'b0, "R10 entry refused after reset");
        wr(3'b101);
        tick(2);

        // R4: row activation after precharge
        n = cyc;
        push(n + 1, P_PRE, 1'b0, 3'b000, 1'b0, "R2 precharge after reset");
        wr(3'b010);
        tick(PRE_CYC + 2);
        bank_act = 1'b1;
        tick(1);
        bank_act = 1'b0;
        n = cyc;
        push(n + 1, P_NOP, 1'b0, 3'b000, 1'b0, "R4 entry refused after activation");
        push(n + 2, P_NOP, 1'b0, 3'b000, 1'b0, "R4 no entry later");
        wr(3'b101);
        tick(3);

        if (sb.size() != 0) begin
            check(1'b0, "scoreboard", $sformatf("%0d left", sb.size()), "0 left");
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule